// File: doc/BRIEF.md
# Serial Port FIFO Register Front End

This block is the register layer that sits between a simple 32-bit memory-mapped bus and the two data queues of a synchronous serial port. Software writes the data register to queue a word for transmission and reads the same register to take the oldest received word. A read-only status register reports how full both queues are and whether the port is busy. A divisor register holds the clock prescale value that the serial clock generator uses.

The serial engine connects on the other side. It takes words from the transmit queue through a pop strobe and delivers received words through a push strobe. The engine also drives a frame-in-progress input. Two inputs shape the data path: a 4-bit frame size code and a narrow-transmit mode, and the port enable input gates the serial side. Both queues keep their contents while the port is disabled, so software can preload the transmit queue before it turns the port on.

Top module: `sport_regs`

## Requirements
- R1: After reset the status register reads 0x3 when no frame is active. The divisor register reads 0, a data register read returns 0, the overrun flag is 0 and `tx_valid` is 0.
- R2: A bus write to offset 0x08 appends the word to the transmit queue. `tx_data` shows the oldest entry, and entries leave in write order on `tx_pop`.
- R3: When `narrow_mode` is 1, a transmit entry keeps only bits 7:0 and stores zeros above them, whatever the size code.
- R4: The transmit queue holds 8 entries. A write while it is full is dropped and leaves the stored entries unchanged, and status bit 1 reads 0 while it is full.
- R5: A bus read of offset 0x08 returns the oldest received entry in bits 15:0 with zeros in bits 31:16 and removes that entry. Received words are stored right-justified, with zeros above the frame size.
- R6: A data read while the receive queue is empty returns 0 and does not advance the queue, so the next received word is the one that a later read returns.
- R7: A serial push into a full 8-entry receive queue is discarded. It sets `rx_overrun`, which stays 1 until reset, and status bit 3 reads 1 while the queue is full.
- R8: The status register at offset 0x0C has these bits: bit 0 = transmit queue empty, bit 1 = transmit queue not full, bit 2 = receive queue not empty, bit 3 = receive queue full, bit 4 = busy. Bits 31:5 read 0.
- R9: The busy bit is 1 when `frame_active` is 1 or when the transmit queue holds any entry. Otherwise it is 0.
- R10: While `port_en` is 0, `tx_pop` and `rx_push` have no effect and `tx_valid` is 0. Both queues keep their contents, and bus writes still fill the transmit queue.
- R11: The divisor register at offset 0x10 stores write bits 7:1 and forces bit 0 to 0. It reads with bits 31:8 as 0 and drives `prescale`.
- R12: The size code gives a frame size of code+1 bits. Codes 0 to 2 act as 4 bits, and code 15 gives 16 bits. Transmit entries are masked to this size when they are written, and receive entries when they are pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the read strobe cycle |
| port_en | input | 1 | Serial port enable |
| frame_active | input | 1 | Serial engine is shifting a frame |
| size_code | input | 4 | Frame size minus one |
| narrow_mode | input | 1 | Transmit entries limited to 8 bits |
| tx_valid | output | 1 | Transmit entry available to the engine |
| tx_data | output | 16 | Oldest transmit entry |
| tx_pop | input | 1 | Engine takes the oldest transmit entry |
| rx_push | input | 1 | Engine delivers a received word |
| rx_data | input | 16 | Received word |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| prescale | output | 8 | Clock divisor, always even |

## Verification
The assertions check, on every cycle, that neither queue's count goes past its depth and that a push into a full queue leaves the count unchanged. They also check that a pop of an empty queue moves nothing, that the transmit count cannot change while the port is disabled unless the bus writes, and that the overrun flag never clears and the divisor never turns odd. Only the bench scenarios can show the values themselves. These are the ordering and masking of queued words for each size code and for narrow mode, the exact status words, the dropped ninth entries, and that preloaded words are still there after the port is enabled.

// File: rtl/sport_pkg.sv
// Shared constants for the serial port register front end.
// Assumes a 32-bit bus with byte offsets and 16-bit serial words.
package sport_pkg;
    localparam int BUS_W       = 32;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 16;
    localparam int SIZE_CODE_W = 4;
    localparam int QUEUE_DEPTH = 8;
    localparam int DIV_W       = 8;
    localparam int NARROW_W    = 8;
    localparam int MIN_CODE    = 3;

    localparam logic [ADDR_W-1:0] OFF_DATA   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_DIV    = 8'h10;
endpackage

// File: rtl/sport_width_mask.sv
// Builds the transmit and receive bit masks from the frame size code.
// Assumes codes below MIN_CODE act as MIN_CODE. Narrow mode limits only
// the transmit mask to NARROW_W bits.
module sport_width_mask
    import sport_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int CODE_W = SIZE_CODE_W,
    parameter int NW     = NARROW_W
) (
    input  logic [CODE_W-1:0] size_code,
    input  logic              narrow_mode,
    output logic [W-1:0]      tx_mask,
    output logic [W-1:0]      rx_mask
);
    logic [CODE_W-1:0] eff_code;

    // Clamp the size code to the smallest legal frame.
    assign eff_code = (size_code < CODE_W'(MIN_CODE)) ? CODE_W'(MIN_CODE) : size_code;

    // One mask bit per data bit: kept when its index is within the frame.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rx_mask[i] = (int'(eff_code) >= i);
        assign tx_mask[i] = narrow_mode ? (i < NW) : rx_mask[i];
    end
endmodule

// File: rtl/sport_fifo.sv
// Synchronous queue with registered read and write pointers and a count.
// A push while full is dropped and reported. A pop while empty is ignored.
// The head entry is presented combinationally from the read pointer.
module sport_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic          dropped,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dropped = push && full;
    assign head    = mem[rd_ptr];
    assign level   = count;

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Store accepted entries.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // R4: the count never exceeds the depth.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R4, R7: a push into a full queue does not change the count.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> $stable(count));

    // R6: a pop from an empty queue moves nothing.
    a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> empty && $stable(rd_ptr));
endmodule

// File: rtl/sport_regs.sv
// Register front end of a synchronous serial port.
// The data offset pushes into the transmit queue on write and pops the
// receive queue on read. The status offset reports queue state and busy.
// The divisor offset holds an even clock prescale value.
// Assumes one-cycle bus strobes and combinational read data.
module sport_regs
    import sport_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr_en,
    input  logic                   bus_rd_en,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    input  logic                   port_en,
    input  logic                   frame_active,
    input  logic [SIZE_CODE_W-1:0] size_code,
    input  logic                   narrow_mode,
    output logic                   tx_valid,
    output logic [DATA_W-1:0]      tx_data,
    input  logic                   tx_pop,
    input  logic                   rx_push,
    input  logic [DATA_W-1:0]      rx_data,
    output logic                   rx_overrun,
    output logic [DIV_W-1:0]       prescale
);
    localparam int LVL_W = $clog2(QUEUE_DEPTH+1);

    logic [DATA_W-1:0] tx_mask, rx_mask, rx_head;
    logic              tx_empty, tx_full, rx_empty, rx_full, rx_drop, tx_drop;
    logic              wr_data, rd_data, busy;
    logic [LVL_W-1:0]  tx_level, rx_level;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W:0]    unused_bits;

    assign unused_bits = {bus_wdata[BUS_W-1:DATA_W], bus_wdata[0], tx_drop, rx_level[0], tx_level[0]};
    assign wr_data = bus_wr_en && (bus_addr == OFF_DATA);
    assign rd_data = bus_rd_en && (bus_addr == OFF_DATA);
    assign busy    = frame_active || !tx_empty;
    assign tx_valid = port_en && !tx_empty;
    assign prescale = div_q;

    sport_width_mask #(.W(DATA_W), .CODE_W(SIZE_CODE_W), .NW(NARROW_W)) u_mask (
        .size_code   (size_code),
        .narrow_mode (narrow_mode),
        .tx_mask     (tx_mask),
        .rx_mask     (rx_mask)
    );

    sport_fifo #(.W(DATA_W), .DEPTH(QUEUE_DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_data),
        .push_data (bus_wdata[DATA_W-1:0] & tx_mask),
        .pop       (tx_pop && port_en),
        .head      (tx_data),
        .empty     (tx_empty),
        .full      (tx_full),
        .dropped   (tx_drop),
        .level     (tx_level)
    );

    sport_fifo #(.W(DATA_W), .DEPTH(QUEUE_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push && port_en),
        .push_data (rx_data & rx_mask),
        .pop       (rd_data),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full),
        .dropped   (rx_drop),
        .level     (rx_level)
    );

    // Sticky overrun: set by a discarded serial push, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_overrun <= 1'b0;
        else if (rx_drop) rx_overrun <= 1'b1;
    end

    // Divisor register: bit 0 is always stored as zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (bus_wr_en && bus_addr == OFF_DIV)
            div_q <= {bus_wdata[DIV_W-1:1], 1'b0};
    end

    // Read multiplexer; unmapped offsets and an empty receive queue read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_DATA:   if (!rx_empty) bus_rdata[DATA_W-1:0] = rx_head;
            OFF_STATUS: bus_rdata[4:0] = {busy, rx_full, !rx_empty, !tx_full, tx_empty};
            OFF_DIV:    bus_rdata[DIV_W-1:0] = div_q;
            default:    bus_rdata = '0;
        endcase
    end

    // R10: with the port disabled, only a bus write may change the transmit count.
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en && !wr_data |=> $stable(tx_level));

    // R10: the receive count cannot grow while the port is disabled.
    a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> rx_level <= $past(rx_level));

    // R7: overrun never clears once set.
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun);

    // R9: an entry offered to the engine implies busy.
    a_r9_busy_when_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    // R11: the divisor stays even.
    a_r11_div_even: assert property (@(posedge clk) disable iff (!rst_n)
        !prescale[0]);
endmodule

// File: tb/sport_regs_bench.sv
`timescale 1ns/1ps
module sport_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        port_en = 1'b0, frame_active = 1'b0, narrow_mode = 1'b0;
    logic [3:0]  size_code = 4'd15;
    logic        tx_valid, tx_pop = 1'b0, rx_push = 1'b0, rx_overrun;
    logic [15:0] tx_data, rx_data = '0;
    logic [7:0]  prescale;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    sport_regs u_sport_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_en(port_en), .frame_active(frame_active), .size_code(size_code),
        .narrow_mode(narrow_mode), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
        .rx_overrun(rx_overrun), .prescale(prescale)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] size_mask(input logic [3:0] code);
        int bits = (code < 3) ? 4 : int'(code) + 1;
        return 16'((32'h1 << bits) - 1);
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk); bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd_en = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd_en = 1'b0;
    endtask

    task automatic serial_pop();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic serial_push(input logic [15:0] d);
        @(negedge clk); rx_push = 1'b1; rx_data = d;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        bus_read(8'h0C, r); chk("R1 status", r, 32'h3);
        bus_read(8'h10, r); chk("R1 divisor", r, 32'h0);
        bus_read(8'h08, r); chk("R1 data", r, 32'h0);
        chk("R1 overrun", {31'b0, rx_overrun}, 32'h0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    endtask

    task automatic t_tx_order();
        logic [31:0] r;
        port_en = 1'b1; size_code = 4'd7;
        bus_write(8'h08, 32'hFFFF_ABCD);
        bus_write(8'h08, 32'h0000_1234);
        bus_write(8'h08, 32'h0000_FFFF);
        bus_read(8'h0C, r); chk("R8 R9 status with tx loaded", r, 32'h12);
        chk("R2 head 1", {16'b0, tx_data}, 32'h00CD);
        serial_pop(); chk("R2 head 2", {16'b0, tx_data}, 32'h0034);
        serial_pop(); chk("R2 head 3", {16'b0, tx_data}, 32'h00FF);
        serial_pop();
        bus_read(8'h0C, r); chk("R9 idle status", r, 32'h3);
        for (int c = 0; c < 16; c += 5) begin
            size_code = 4'(c);
            bus_write(8'h08, 32'h0000_F3A7);
            chk("R12 size mask", {16'b0, tx_data}, {16'b0, 16'hF3A7 & size_mask(4'(c))});
            serial_pop();
        end
    endtask

    task automatic t_narrow();
        size_code = 4'd15; narrow_mode = 1'b1;
        bus_write(8'h08, 32'h0000_BEEF);
        chk("R3 narrow entry", {16'b0, tx_data}, 32'h00EF);
        serial_pop();
        narrow_mode = 1'b0;
    endtask

    task automatic t_tx_full();
        logic [31:0] r;
        size_code = 4'd15;
        for (int i = 0; i < 9; i++) bus_write(8'h08, 32'h100 + i);
        bus_read(8'h0C, r); chk("R4 not-full bit clear", r & 32'h2, 32'h0);
        for (int i = 0; i < 8; i++) begin
            chk("R4 drained order", {16'b0, tx_data}, 32'h100 + i);
            serial_pop();
        end
        chk("R4 ninth dropped", {31'b0, tx_valid}, 32'h0);
    endtask

    task automatic t_rx();
        logic [31:0] r;
        size_code = 4'd7;
        serial_push(16'h3C5A);
        serial_push(16'h0081);
        bus_read(8'h0C, r); chk("R8 rx not empty", r, 32'h7);
        bus_read(8'h08, r); chk("R5 first rx", r, 32'h5A);
        bus_read(8'h08, r); chk("R5 second rx", r, 32'h81);
        bus_read(8'h08, r); chk("R6 empty read", r, 32'h0);
        serial_push(16'hFF42);
        bus_read(8'h08, r); chk("R6 pointer held", r, 32'h42);
    endtask

    task automatic t_rx_full();
        logic [31:0] r;
        size_code = 4'd15;
        for (int i = 0; i < 9; i++) serial_push(16'h200 + 16'(i));
        bus_read(8'h0C, r); chk("R7 full status", r, 32'hF);
        chk("R7 overrun set", {31'b0, rx_overrun}, 32'h1);
        for (int i = 0; i < 8; i++) begin
            bus_read(8'h08, r); chk("R7 drained order", r, 32'h200 + i);
        end
        chk("R7 overrun sticky", {31'b0, rx_overrun}, 32'h1);
    endtask

    task automatic t_disable();
        logic [31:0] r;
        port_en = 1'b0;
        bus_write(8'h08, 32'h0000_0011);
        chk("R10 tx_valid gated", {31'b0, tx_valid}, 32'h0);
        serial_pop();
        serial_push(16'h0055);
        bus_read(8'h0C, r); chk("R10 state kept while disabled", r, 32'h12);
        port_en = 1'b1;
        #1 chk("R10 preload kept", {15'b0, tx_valid, tx_data}, 32'h1_0011);
        serial_pop();
        frame_active = 1'b1;
        bus_read(8'h0C, r); chk("R9 frame busy", r, 32'h13);
        frame_active = 1'b0;
    endtask

    task automatic t_divisor();
        logic [31:0] r;
        bus_write(8'h10, 32'hFFFF_01FF);
        bus_read(8'h10, r); chk("R11 odd write", r, 32'hFE);
        chk("R11 prescale port", {24'b0, prescale}, 32'hFE);
        bus_write(8'h10, 32'h0000_0056);
        bus_read(8'h10, r); chk("R11 even write", r, 32'h56);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_order();
        t_narrow();
        t_tx_full();
        t_rx();
        t_rx_full();
        t_disable();
        t_divisor();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule